// File: doc/BRIEF.md
# Video Identification Status Bus Port

This block sits beside a video identification decoder and gives a host controller access to it over a two-wire serial bus (I2C), acting as a slave. It has no register pointer. A write transfer carries exactly one control byte. A read transfer returns exactly two status bytes, built from the decoded identification word, the decoder's validity flag and the levels on two dual-purpose pins. Both status bytes are captured together when the address is acknowledged.

The two dual-purpose pins ("pin A", the letterbox flag, and "pin B", the wide-screen flag) can each be a direct decoder output, a general-purpose output, or a general-purpose input. Two control bits choose the arrangement. A strap input can take the bus out of use entirely. In that case every control value is forced to zero and both pins carry the decoder result. SCL and SDA are brought into the clock domain through two flops and a glitch filter. The slave changes SDA only while SCL is low. The block has no streaming data path, so no valid/ready handshake appears. The decoder fields, the control fields and the pin pins are plain levels.

Top module: `vid_id_busport`

## Requirements
- R1: The slave answers only to the address byte 0x40 (write) or 0x41 (read), which is 7-bit address 0x20 with the direction in bit 0. Any other address gets no ACK and has no effect.
- R2: In a write, the slave ACKs the address and the first data byte, and that byte becomes the control byte. Any further data byte in the same transfer is NACKed and leaves the control byte unchanged.
- R3: In a read, the slave sends two bytes, most significant bit first. Byte 0 is {ID5, ID4, ID3, ID1, ID2, valid, pin A level, pin B level}. Byte 1 is {ID13..ID6}. ID(k) is `id_word[k-1]`. A master NACK ends the transfer.
- R4: Both read bytes come from one snapshot, taken at the address ACK. Changes on `id_word` later in the transfer do not show up in it.
- R5: Control bits 5:4 = 00 makes both pins outputs. Pin A drives ID2 AND valid, and pin B drives ID1 AND valid.
- R6: Control bits 5:4 = 01 makes both pins outputs. Pin A drives control bit 7 and pin B drives control bit 6.
- R7: Control bits 5:4 = 10 makes pin A an input (not driven) and pin B an output with the value of bit 6. Control bits 5:4 = 11 makes both pins inputs. The level on an input pin is what byte 0 reports.
- R8: Control bit 3 appears on `cfg_test`, bit 2 on `cfg_hold_off`, bit 1 on `cfg_exact_line` and bit 0 on `cfg_soft_rst`.
- R9: While `rst_n` is low, neither pin is driven, SDA is released and the control byte is cleared. After reset, the pins are direct outputs.
- R10: With `bus_mode` low, the bus gets no ACK and no SDA drive. The effective control byte is zero: both pins are direct outputs and all `cfg_*` outputs are low.
- R11: The slave changes SDA to driven-low only while SCL is low. A START anywhere, including a repeated START, restarts address reception.
- R12: An SCL pulse shorter than `FILT_CYC` clock cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_mode | input | 1 | High: serial bus in use; low: strap mode |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| id_word | input | 13 | Decoded identification bits, ID1 in bit 0 |
| id_valid | input | 1 | Decoder validity flag |
| pa_i | input | 1 | Pin A pad level |
| pa_o | output | 1 | Pin A output value |
| pa_oe | output | 1 | Pin A output enable |
| pb_i | input | 1 | Pin B pad level |
| pb_o | output | 1 | Pin B output value |
| pb_oe | output | 1 | Pin B output enable |
| cfg_test | output | 1 | Control bit 3 |
| cfg_hold_off | output | 1 | Control bit 2 |
| cfg_exact_line | output | 1 | Control bit 1 |
| cfg_soft_rst | output | 1 | Control bit 0 |

## Verification
A bit counter that slips or a protocol state that goes wrong shows up within one byte time. It appears as an ACK missing in the ninth clock or a read byte shifted by one bit. A glitch let through by the filter has the same effect as a slipped counter. A wrongly latched control byte shows up on the pin enables and `cfg_*` outputs a few cycles after the data ACK. A snapshot taken at the wrong moment shows up only in the second read byte, so the tests change the decoder word between the two bytes.

// File: rtl/vib_pkg.sv
package vib_pkg;
  localparam int ID_W   = 13;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
  } bus_st_t;

  typedef enum logic [1:0] {
    PF_DIRECT   = 2'b00,
    PF_BOTH_OUT = 2'b01,
    PF_A_IN     = 2'b10,
    PF_BOTH_IN  = 2'b11
  } pinfn_t;

  typedef struct packed {
    logic       pa_val;
    logic       pb_val;
    logic [1:0] port;
    logic       test;
    logic       hold_off;
    logic       exact_line;
    logic       soft_rst;
  } ctl_t;
endpackage

// File: rtl/vib_line_sync.sv
module vib_line_sync #(
  parameter int   STAGES   = 2,
  parameter int   FILT_CYC = 3,
  parameter logic INIT     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{INIT}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  generate
    if (FILT_CYC <= 1) begin : g_plain
      assign q = ff[STAGES-1];
    end else begin : g_filt
      localparam int CW = $clog2(FILT_CYC + 1);
      logic [CW-1:0] cnt;
      logic          qr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
          qr  <= INIT;
        end else if (ff[STAGES-1] == qr) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
          qr  <= ff[STAGES-1];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign q = qr;
    end
  endgenerate
endmodule

// File: rtl/vib_i2c_slave.sv
module vib_i2c_slave
  import vib_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl,
  input  logic              sda,
  input  logic [BYTE_W-1:0] rd_b0,
  input  logic [BYTE_W-1:0] rd_b1,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              snap_stb,
  output logic              rd_busy
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sr, tx;
  logic              scl_q, sda_q, rw, wr_seen, byte_idx, mack, drive;
  logic              rise, fall, start_c, stop_c;

  assign rise    = scl & ~scl_q;
  assign fall    = ~scl & scl_q;
  assign start_c = scl & scl_q & sda_q & ~sda;
  assign stop_c  = scl & scl_q & ~sda_q & sda;
  assign sda_oe  = drive;
  assign rd_busy = (st == S_RDAT) || (st == S_RACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0; rw <= 1'b0;
      wr_seen <= 1'b0; byte_idx <= 1'b0; mack <= 1'b0; drive <= 1'b0;
      wr_stb <= 1'b0; wr_byte <= '0; snap_stb <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      snap_stb <= 1'b0;
      if (!en) begin
        st    <= S_IDLE;
        drive <= 1'b0;
      end else if (start_c) begin
        st    <= S_ADDR;
        cnt   <= '0;
        drive <= 1'b0;
      end else if (stop_c) begin
        st    <= S_IDLE;
        drive <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (rise) begin
              sr  <= {sr[BYTE_W-2:0], sda};
              cnt <= cnt + 1'b1;
            end else if (fall && cnt == FULL) begin
              if (sr[BYTE_W-1:1] == DEV_ADDR) begin
                st       <= S_AACK;
                drive    <= 1'b1;
                rw       <= sr[0];
                snap_stb <= sr[0];
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_AACK: begin
            if (fall) begin
              cnt <= '0;
              if (rw) begin
                st       <= S_RDAT;
                tx       <= rd_b0;
                drive    <= ~rd_b0[BYTE_W-1];
                byte_idx <= 1'b0;
              end else begin
                st      <= S_WDAT;
                drive   <= 1'b0;
                wr_seen <= 1'b0;
              end
            end
          end
          S_WDAT: begin
            if (rise) begin
              sr  <= {sr[BYTE_W-2:0], sda};
              cnt <= cnt + 1'b1;
            end else if (fall && cnt == FULL) begin
              st <= S_WACK;
              if (!wr_seen) begin
                drive   <= 1'b1;
                wr_stb  <= 1'b1;
                wr_byte <= sr;
                wr_seen <= 1'b1;
              end
            end
          end
          S_WACK: begin
            if (fall) begin
              drive <= 1'b0;
              cnt   <= '0;
              st    <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (rise) begin
              cnt <= cnt + 1'b1;
            end else if (fall) begin
              if (cnt == FULL) begin
                drive <= 1'b0;
                st    <= S_RACK;
              end else begin
                tx    <= {tx[BYTE_W-2:0], 1'b0};
                drive <= ~tx[BYTE_W-2];
              end
            end
          end
          S_RACK: begin
            if (rise) begin
              mack <= ~sda;
            end else if (fall) begin
              if (mack && !byte_idx) begin
                byte_idx <= 1'b1;
                tx       <= rd_b1;
                drive    <= ~rd_b1[BYTE_W-1];
                cnt      <= '0;
                st       <= S_RDAT;
              end else begin
                drive <= 1'b0;
                st    <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vib_pin_mux.sv
module vib_pin_mux
  import vib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] port,
  input  logic       pa_val,
  input  logic       pb_val,
  input  logic       dir_a,
  input  logic       dir_b,
  output logic       pa_o,
  output logic       pa_oe,
  output logic       pb_o,
  output logic       pb_oe
);
  logic a_o, a_oe, b_o, b_oe;

  always_comb begin
    a_o = 1'b0; a_oe = 1'b0; b_o = 1'b0; b_oe = 1'b0;
    case (pinfn_t'(port))
      PF_DIRECT:   begin a_oe = 1'b1; a_o = dir_a; b_oe = 1'b1; b_o = dir_b; end
      PF_BOTH_OUT: begin a_oe = 1'b1; a_o = pa_val; b_oe = 1'b1; b_o = pb_val; end
      PF_A_IN:     begin b_oe = 1'b1; b_o = pb_val; end
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_o <= 1'b0; pa_oe <= 1'b0; pb_o <= 1'b0; pb_oe <= 1'b0;
    end else begin
      pa_o <= a_o; pa_oe <= a_oe; pb_o <= b_o; pb_oe <= b_oe;
    end
  end
endmodule

// File: rtl/vid_id_busport.sv
module vid_id_busport
  import vib_pkg::*;
#(
  parameter int         FILT_CYC = 3,
  parameter logic [6:0] DEV_ADDR = 7'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_mode,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic [ID_W-1:0] id_word,
  input  logic            id_valid,
  input  logic            pa_i,
  output logic            pa_o,
  output logic            pa_oe,
  input  logic            pb_i,
  output logic            pb_o,
  output logic            pb_oe,
  output logic            cfg_test,
  output logic            cfg_hold_off,
  output logic            cfg_exact_line,
  output logic            cfg_soft_rst
);
  localparam int N_BUS = 2;
  localparam int N_PIN = 3;

  logic [N_BUS-1:0]  bus_raw, bus_s;
  logic [N_PIN-1:0]  pin_raw, pin_s;
  logic              scl_f, sda_f, mode_s, pa_s, pb_s;
  logic              wr_stb, snap_stb, rd_busy;
  logic [BYTE_W-1:0] wr_byte, snap_b0, snap_b1;
  ctl_t              ctl_reg, ctl_eff;

  assign bus_raw = {sda_i, scl_i};
  assign pin_raw = {bus_mode, pb_i, pa_i};

  generate
    for (genvar g = 0; g < N_BUS; g++) begin : g_bus
      vib_line_sync #(.STAGES(2), .FILT_CYC(FILT_CYC), .INIT(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_raw[g]), .q(bus_s[g]));
    end
    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
      vib_line_sync #(.STAGES(2), .FILT_CYC(1), .INIT(1'b0)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_s[g]));
    end
  endgenerate

  assign scl_f  = bus_s[0];
  assign sda_f  = bus_s[1];
  assign pa_s   = pin_s[0];
  assign pb_s   = pin_s[1];
  assign mode_s = pin_s[2];

  vib_i2c_slave #(.DEV_ADDR(DEV_ADDR)) u_slave (
    .clk(clk), .rst_n(rst_n), .en(mode_s), .scl(scl_f), .sda(sda_f),
    .rd_b0(snap_b0), .rd_b1(snap_b1), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .snap_stb(snap_stb), .rd_busy(rd_busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_reg <= '0;
      snap_b0 <= '0;
      snap_b1 <= '0;
    end else begin
      if (wr_stb) ctl_reg <= ctl_t'(wr_byte);
      if (snap_stb) begin
        snap_b0 <= {id_word[4], id_word[3], id_word[2], id_word[0], id_word[1],
                    id_valid, pa_s, pb_s};
        snap_b1 <= id_word[12:5];
      end
    end
  end

  assign ctl_eff = mode_s ? ctl_reg : '0;

  vib_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .port(ctl_eff.port),
    .pa_val(ctl_eff.pa_val), .pb_val(ctl_eff.pb_val),
    .dir_a(id_word[1] & id_valid), .dir_b(id_word[0] & id_valid),
    .pa_o(pa_o), .pa_oe(pa_oe), .pb_o(pb_o), .pb_oe(pb_oe));

  assign cfg_test       = ctl_eff.test;
  assign cfg_hold_off   = ctl_eff.hold_off;
  assign cfg_exact_line = ctl_eff.exact_line;
  assign cfg_soft_rst   = ctl_eff.soft_rst;
endmodule

// File: rtl/vib_chk.sv
module vib_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_f,
  input logic        mode_s,
  input logic [7:0]  ctl_eff,
  input logic [12:0] id_word,
  input logic        id_valid,
  input logic        pa_o,
  input logic        pa_oe,
  input logic        pb_o,
  input logic        pb_oe,
  input logic        rd_busy,
  input logic [7:0]  snap_b0,
  input logic [7:0]  snap_b1
);
  // R11
  sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  // R10
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> !sda_oe);

  // R7
  both_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_eff[5:4] == 2'b11) |=> (!pa_oe && !pb_oe));

  // R5
  direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_eff[5:4] == 2'b00) |=> (pa_oe && pb_oe &&
      pa_o == $past(id_word[1] & id_valid) && pb_o == $past(id_word[0] & id_valid)));

  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && $past(rd_busy)) |-> $stable({snap_b0, snap_b1}));

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_pins_chk: assert (!pa_oe && !pb_oe && !sda_oe);
    end
  end
endmodule

bind vid_id_busport vib_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f), .mode_s(mode_s),
  .ctl_eff(ctl_eff), .id_word(id_word), .id_valid(id_valid),
  .pa_o(pa_o), .pa_oe(pa_oe), .pb_o(pb_o), .pb_oe(pb_oe),
  .rd_busy(rd_busy), .snap_b0(snap_b0), .snap_b1(snap_b1));

// File: tb/vid_id_busport_test.sv
`timescale 1ns/1ps
module vid_id_busport_test;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_mode = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [12:0] id_word = '0;
  logic id_valid = 1'b0;
  logic ext_a = 1'b0, ext_b = 1'b0;
  logic sda_oe, pa_o, pa_oe, pb_o, pb_oe;
  logic cfg_test, cfg_hold_off, cfg_exact_line, cfg_soft_rst;
  logic sda_line, pa_pad, pb_pad;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign pa_pad = pa_oe ? pa_o : ext_a;
  assign pb_pad = pb_oe ? pb_o : ext_b;

  vid_id_busport uut (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .id_word(id_word), .id_valid(id_valid),
    .pa_i(pa_pad), .pa_o(pa_o), .pa_oe(pa_oe), .pb_i(pb_pad), .pb_o(pb_o), .pb_oe(pb_oe),
    .cfg_test(cfg_test), .cfg_hold_off(cfg_hold_off),
    .cfg_exact_line(cfg_exact_line), .cfg_soft_rst(cfg_soft_rst));

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_b0(input logic [12:0] id, input logic v, input logic a, input logic b);
    return {id[4], id[3], id[2], id[0], id[1], v, a, b};
  endfunction

  function automatic logic [3:0] pins();
    return {pa_oe, pb_oe, pa_o, pb_o};
  endfunction

  function automatic logic [3:0] cfgs();
    return {cfg_test, cfg_hold_off, cfg_exact_line, cfg_soft_rst};
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic bit_out(input logic b, input logic glitch);
    sda_m = b;
    if (glitch) begin
      wq(8); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q - 9);
    end else wq(Q);
    scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic r);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    r = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic [7:0] gmask, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_out(b[i], gmask[i]);
    bit_in(r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(~mack, 1'b0);
  endtask

  task automatic write_ctl(input logic [7:0] v, input string req);
    logic a;
    bus_start;
    send_byte(8'h40, 8'h00, a); chk({req, " addr ack"}, a, 1'b1);
    send_byte(v, 8'h00, a);     chk({req, " data ack"}, a, 1'b1);
    bus_stop; wq(6);
  endtask

  task automatic read_pair(output logic [7:0] b0, output logic [7:0] b1, output logic ack);
    bus_start;
    send_byte(8'h41, 8'h00, ack);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    bus_stop; wq(4);
  endtask

  task automatic t_reset;
    wq(3);
    chk("R9 reset pins", {pa_oe, pb_oe, sda_oe}, 3'b000);
    chk("R9 reset cfg", cfgs(), 4'b0000);
    rst_n = 1'b1; wq(6);
    chk("R9 after reset direct", {pa_oe, pb_oe}, 2'b11);
  endtask

  task automatic t_direct;
    id_word = 13'h0002; id_valid = 1'b1; wq(4);
    chk("R5 letterbox only", pins(), 4'b1110);
    id_valid = 1'b0; wq(4);
    chk("R5 invalid gates", pins(), 4'b1100);
    id_word = 13'h0001; id_valid = 1'b1; wq(4);
    chk("R5 wide only", pins(), 4'b1101);
  endtask

  task automatic t_badaddr;
    logic a;
    bus_start; send_byte(8'h52, 8'h00, a); bus_stop; wq(4);
    chk("R1 foreign address nack", a, 1'b0);
    chk("R1 foreign address no effect", pins(), 4'b1101);
  endtask

  task automatic t_write;
    write_ctl(8'b1001_1010, "R2");
    chk("R6 both outputs 1/0", pins(), 4'b1110);
    chk("R8 cfg fields", cfgs(), 4'b1010);
    write_ctl(8'b0101_0101, "R2");
    chk("R6 both outputs 0/1", pins(), 4'b1101);
    chk("R8 cfg fields alt", cfgs(), 4'b0101);
  endtask

  task automatic t_extra;
    logic a;
    bus_start;
    send_byte(8'h40, 8'h00, a);
    send_byte(8'b1001_1010, 8'h00, a); chk("R2 first byte ack", a, 1'b1);
    send_byte(8'b0011_0000, 8'h00, a); chk("R2 second byte nack", a, 1'b0);
    bus_stop; wq(6);
    chk("R2 second byte ignored pins", pins(), 4'b1110);
    chk("R2 second byte ignored cfg", cfgs(), 4'b1010);
  endtask

  task automatic t_mixed;
    logic [7:0] b0, b1; logic a;
    write_ctl(8'b0110_0000, "R7");
    chk("R7 A in B out", {pa_oe, pb_oe, pb_o}, 3'b011);
    ext_a = 1'b1; id_word = 13'h1ABC; id_valid = 1'b1; wq(4);
    read_pair(b0, b1, a);
    chk("R1 read address ack", a, 1'b1);
    chk("R3 byte0 mixed", b0, exp_b0(13'h1ABC, 1'b1, 1'b1, 1'b1));
    chk("R3 byte1 mixed", b1, 8'hD5);
  endtask

  task automatic t_inputs;
    logic [7:0] b0, b1; logic a;
    write_ctl(8'b1111_0000, "R7");
    chk("R7 both inputs", {pa_oe, pb_oe}, 2'b00);
    ext_a = 1'b0; ext_b = 1'b1; id_word = 13'h0A53; id_valid = 1'b0; wq(4);
    read_pair(b0, b1, a);
    chk("R3 byte0 inputs", b0, exp_b0(13'h0A53, 1'b0, 1'b0, 1'b1));
    chk("R3 byte1 inputs", b1, 8'h52);
  endtask

  task automatic t_snapshot;
    logic [7:0] b0, b1; logic a;
    id_word = 13'h1F00; id_valid = 1'b1; wq(4);
    bus_start;
    send_byte(8'h41, 8'h00, a);
    recv_byte(1'b1, b0);
    id_word = 13'h00FF;
    recv_byte(1'b0, b1);
    bus_stop; wq(4);
    chk("R4 snapshot byte1", b1, 8'hF8);
    read_pair(b0, b1, a);
    chk("R4 fresh snapshot", b1, 8'h07);
  endtask

  task automatic t_restart;
    logic [7:0] b0, b1; logic a;
    bus_start;
    send_byte(8'h40, 8'h00, a);
    bus_start;
    send_byte(8'h41, 8'h00, a); chk("R11 repeated start ack", a, 1'b1);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    bus_stop; wq(4);
    chk("R11 repeated start data", b1, 8'h07);
    chk("R11 no drive after stop", sda_oe, 1'b0);
  endtask

  task automatic t_glitch;
    logic a;
    bus_start;
    send_byte(8'h40, 8'h00, a);
    send_byte(8'b0001_0000, 8'b0010_1000, a);
    chk("R12 glitched byte ack", a, 1'b1);
    bus_stop; wq(6);
    chk("R12 glitched byte value", pins(), 4'b1100);
    chk("R12 glitched cfg", cfgs(), 4'b0000);
  endtask

  task automatic t_strap;
    logic a;
    write_ctl(8'b1111_1111, "R10");
    bus_mode = 1'b0; id_word = 13'h0003; id_valid = 1'b1; wq(6);
    chk("R10 strap direct pins", pins(), 4'b1111);
    chk("R10 strap cfg zero", cfgs(), 4'b0000);
    bus_start; send_byte(8'h40, 8'h00, a); bus_stop; wq(4);
    chk("R10 strap bus ignored", a, 1'b0);
    bus_mode = 1'b1; wq(6);
  endtask

  task automatic t_hwreset;
    rst_n = 1'b0; wq(2);
    chk("R9 mid reset pins", {pa_oe, pb_oe, sda_oe}, 3'b000);
    rst_n = 1'b1; wq(6);
    chk("R9 control cleared", cfgs(), 4'b0000);
    chk("R9 direct after reset", pins(), 4'b1111);
  endtask

  initial begin
    t_reset;
    t_direct;
    t_badaddr;
    t_write;
    t_extra;
    t_mixed;
    t_inputs;
    t_snapshot;
    t_restart;
    t_glitch;
    t_strap;
    t_hwreset;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule